// File: doc/BRIEF.md
# Ethernet Station Address Filter

This block sits beside the receive and transmit paths of a 10 Mb/s Ethernet MAC and decides whether a frame's station address is one this node cares about. The frame arrives as a byte stream, one byte per strobe, after a start-of-frame pulse. The operating mode is sampled on that pulse. When receiving, or in loopback, the block takes the destination address from the first six frame bytes. When transmitting, it takes the source address from frame bytes seven to twelve of the copy that loops back from the line. It then compares the captured address against sixteen host-programmable entries, each gated by its own enable bit, and against a fixed broadcast entry that can never be overwritten.

The result appears one cycle after the last address byte. It is a one-cycle valid pulse, together with a match flag, the lowest matching entry index, a broadcast flag and a reject flag for received frames that match nothing. In transmit mode the block also checks the looped-back source address against the address the transmitter reports it sent, and raises a packet-monitored-bad flag when the two differ. The host loads entries through a write port. The table in use is frozen for the length of a frame, so a write made during a frame first applies to the following frame.

Top module: `eth_addr_filter`

## Requirements
- R1: After reset, every result output is 0 and every programmable entry is disabled, so an all-zero address does not match.
- R2: Mode is sampled on `frame_start_i` (0 receive, 1 loopback, 2 transmit, 3 treated as receive). In receive and loopback mode the address is the first six strobed bytes after the start pulse, with the first byte as bits 47:40.
- R3: In transmit mode the address is strobed bytes 7 to 12 after the start pulse (zero-based indices 6 to 11), with byte 7 as bits 47:40.
- R4: `result_valid_o` is high for exactly one cycle, beginning one cycle after the clock edge that samples the last address byte. The other result outputs hold their values until the next `frame_start_i`, which clears them to 0.
- R5: An enabled entry equal to the address sets `match_o`, and `match_idx_o` gives the lowest such index. A disabled entry never matches, and `match_idx_o` is 0 when no programmable entry hits.
- R6: An all-ones address always sets `bcast_o` and `match_o`, whatever the table holds.
- R7: Entries compare all 48 bits exactly, so individual addresses and group addresses (bit 40 set) may be mixed freely in the table.
- R8: In receive or loopback mode, `reject_o` is set when `match_o` is 0. It is never set in transmit mode.
- R9: In transmit mode, `pmb_o` is set when the captured source address differs from `tx_sa_i`. It is never set in the other modes.
- R10: A host write updates a staging copy of the entry. The compare table takes the staged contents on `frame_start_i`, so a write made during a frame has no effect on that frame's result.
- R11: A byte strobe in the same cycle as `frame_start_i` is not counted, and bytes outside the address window do not change the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start-of-frame pulse; samples mode and clears results |
| mode_i | input | 2 | 0 receive, 1 loopback, 2 transmit |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Frame byte |
| tx_sa_i | input | 48 | Source address the transmitter sent |
| host_we_i | input | 1 | Entry write strobe |
| host_idx_i | input | 4 | Entry index to write |
| host_addr_i | input | 48 | Entry address value |
| host_en_i | input | 1 | Entry enable value |
| result_valid_o | output | 1 | One-cycle result pulse |
| match_o | output | 1 | Address matched an entry or broadcast |
| match_idx_o | output | 4 | Lowest matching entry index |
| bcast_o | output | 1 | Address is broadcast |
| reject_o | output | 1 | Received frame matched nothing |
| pmb_o | output | 1 | Looped-back source address differs from the transmitted one |

## Verification
On every cycle the assertions check the timing and hold rules. The valid pulse follows the capture of the last address byte, and only that. Results stay stable between that pulse and the next start pulse, which clears them. The assertions also check how the flags relate to each other: broadcast implies a match, a reject never comes with a match or in transmit mode, and the monitor flag appears only in transmit mode. Only the bench's scenarios can show which address was captured in each mode, that the lowest index wins among duplicates, that disabled entries are ignored, that the source address is compared correctly, and that a write made during a frame is deferred.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
  typedef enum logic [1:0] {
    MODE_RX   = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_TX   = 2'd2,
    MODE_RSVD = 2'd3
  } eaf_mode_e;
endpackage

// File: rtl/eaf_capture.sv
module eaf_capture #(
  parameter int ADDR_BYTES = 6,
  localparam int AW = 8 * ADDR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic          src_sel_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam int CNT_LIM = 2 * ADDR_BYTES;
  localparam int CW = $clog2(CNT_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(CNT_LIM);
  localparam logic [CW-1:0] NB  = CW'(ADDR_BYTES);

  logic [CW-1:0] cnt_q, win_lo;
  logic          in_win, last;

  assign win_lo = src_sel_i ? NB : '0;
  assign in_win = byte_valid_i && (cnt_q >= win_lo) && (cnt_q < win_lo + NB);
  assign last   = in_win && (cnt_q == win_lo + NB - 1'b1);

  // counter saturates so trailing bytes never re-enter a window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      if (byte_valid_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      if (in_win) addr_o <= {addr_o[AW-9:0], byte_i};
      done_o <= last;
    end
  end
endmodule

// File: rtl/eaf_cam_table.sv
module eaf_cam_table #(
  parameter int N  = 16,
  parameter int AW = 48,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic                 wr_en_i,
  input  logic                 load_i,
  output logic [N-1:0][AW-1:0] act_addr_o,
  output logic [N-1:0]         act_en_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [AW-1:0] stg_addr_q;
    logic          stg_en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_addr_q <= '0;
        stg_en_q   <= 1'b0;
      end else if (we_i && idx_i == IW'(g)) begin
        stg_addr_q <= wr_addr_i;
        stg_en_q   <= wr_en_i;
      end
    end

    // compare copy is frozen for the whole frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_addr_o[g] <= '0;
        act_en_o[g]   <= 1'b0;
      end else if (load_i) begin
        act_addr_o[g] <= stg_addr_q;
        act_en_o[g]   <= stg_en_q;
      end
    end
  end
endmodule

// File: rtl/eaf_match.sv
module eaf_match #(
  parameter int N  = 16,
  parameter int AW = 48,
  localparam int IW = $clog2(N)
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [N-1:0][AW-1:0] ent_addr_i,
  input  logic [N-1:0]         ent_en_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o,
  output logic                 bcast_o
);
  logic [N-1:0] hits;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = ent_en_i[g] && (ent_addr_i[g] == addr_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx_o = IW'(i);
    end
  end

  assign hit_o   = |hits;
  assign bcast_o = &addr_i;
endmodule

// File: rtl/eth_addr_filter.sv
module eth_addr_filter #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_BYTES  = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           frame_start_i,
  input  logic [1:0]                     mode_i,
  input  logic                           byte_valid_i,
  input  logic [7:0]                     byte_i,
  input  logic [8*ADDR_BYTES-1:0]        tx_sa_i,
  input  logic                           host_we_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0] host_idx_i,
  input  logic [8*ADDR_BYTES-1:0]        host_addr_i,
  input  logic                           host_en_i,
  output logic                           result_valid_o,
  output logic                           match_o,
  output logic [$clog2(NUM_ENTRIES)-1:0] match_idx_o,
  output logic                           bcast_o,
  output logic                           reject_o,
  output logic                           pmb_o
);
  import eaf_pkg::*;
  localparam int AW = 8 * ADDR_BYTES;
  localparam int IW = $clog2(NUM_ENTRIES);

  eaf_mode_e mode_q;
  logic      is_tx;
  logic [AW-1:0] cap_addr;
  logic          cap_done;
  logic [NUM_ENTRIES-1:0][AW-1:0] ent_addr;
  logic [NUM_ENTRIES-1:0]         ent_en;
  logic          hit, hit_bc;
  logic [IW-1:0] hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mode_q <= MODE_RX;
    else if (frame_start_i) mode_q <= eaf_mode_e'(mode_i);
  end

  assign is_tx = (mode_q == MODE_TX);

  eaf_capture #(.ADDR_BYTES(ADDR_BYTES)) i_capture (
    .clk_i, .rst_ni,
    .start_i     (frame_start_i),
    .byte_valid_i,
    .byte_i,
    .src_sel_i   (is_tx),
    .addr_o      (cap_addr),
    .done_o      (cap_done)
  );

  eaf_cam_table #(.N(NUM_ENTRIES), .AW(AW)) i_table (
    .clk_i, .rst_ni,
    .we_i       (host_we_i),
    .idx_i      (host_idx_i),
    .wr_addr_i  (host_addr_i),
    .wr_en_i    (host_en_i),
    .load_i     (frame_start_i),
    .act_addr_o (ent_addr),
    .act_en_o   (ent_en)
  );

  eaf_match #(.N(NUM_ENTRIES), .AW(AW)) i_match (
    .addr_i     (cap_addr),
    .ent_addr_i (ent_addr),
    .ent_en_i   (ent_en),
    .hit_o      (hit),
    .idx_o      (hit_idx),
    .bcast_o    (hit_bc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      match_o        <= 1'b0;
      match_idx_o    <= '0;
      bcast_o        <= 1'b0;
      reject_o       <= 1'b0;
      pmb_o          <= 1'b0;
    end else if (frame_start_i) begin
      result_valid_o <= 1'b0;
      match_o        <= 1'b0;
      match_idx_o    <= '0;
      bcast_o        <= 1'b0;
      reject_o       <= 1'b0;
      pmb_o          <= 1'b0;
    end else begin
      result_valid_o <= cap_done;
      if (cap_done) begin
        match_o     <= hit | hit_bc;
        match_idx_o <= hit_idx;
        bcast_o     <= hit_bc;
        reject_o    <= !is_tx && !(hit | hit_bc);
        pmb_o       <= is_tx && (cap_addr != tx_sa_i);
      end
    end
  end
endmodule

// File: rtl/eaf_checker.sv
module eaf_checker #(
  parameter int NUM_ENTRIES = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           frame_start_i,
  input logic                           cap_done_i,
  input logic [1:0]                     mode_q_i,
  input logic                           result_valid_o,
  input logic                           match_o,
  input logic [$clog2(NUM_ENTRIES)-1:0] match_idx_o,
  input logic                           bcast_o,
  input logic                           reject_o,
  input logic                           pmb_o
);
  p_valid_follows_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_done_i && !frame_start_i |=> result_valid_o);

  p_valid_needs_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(cap_done_i));

  p_clear_on_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !result_valid_o && !match_o && !bcast_o && !reject_o && !pmb_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i && !cap_done_i |=> $stable({match_o, match_idx_o, bcast_o, reject_o, pmb_o}));

  p_bcast_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> match_o);

  p_reject_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !match_o && mode_q_i != 2'd2);

  p_pmb_tx_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmb_o |-> mode_q_i == 2'd2);
endmodule

bind eth_addr_filter eaf_checker #(.NUM_ENTRIES(NUM_ENTRIES)) i_eaf_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_start_i  (frame_start_i),
  .cap_done_i     (cap_done),
  .mode_q_i       (mode_q),
  .result_valid_o (result_valid_o),
  .match_o        (match_o),
  .match_idx_o    (match_idx_o),
  .bcast_o        (bcast_o),
  .reject_o       (reject_o),
  .pmb_o          (pmb_o)
);

// File: tb/test_eth_addr_filter.sv
module test_eth_addr_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = 8'd0;
  logic [47:0] tx_sa_i = '0;
  logic        host_we_i = 1'b0;
  logic [3:0]  host_idx_i = '0;
  logic [47:0] host_addr_i = '0;
  logic        host_en_i = 1'b0;
  logic        result_valid_o, match_o, bcast_o, reject_o, pmb_o;
  logic [3:0]  match_idx_o;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  logic [47:0] shd_a [16];
  bit          shd_e [16];
  logic [47:0] act_a [16];
  bit          act_e [16];

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  eth_addr_filter i_eth_addr_filter (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(int idx, logic [47:0] a, bit en);
    @(negedge clk_i);
    host_we_i = 1'b1; host_idx_i = 4'(idx); host_addr_i = a; host_en_i = en;
    shd_a[idx] = a; shd_e[idx] = en;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic run_frame(int mode, logic [47:0] da, logic [47:0] sa, logic [47:0] txsa,
                           bit gaps, bit wr, int widx, logic [47:0] waddr, bit wen);
    logic [7:0]  b [14];
    logic [47:0] a;
    int sent, since, vcnt, hidx;
    bit vok, hit, ebc, em, erej, epmb;
    for (int i = 0; i < 6; i++) begin
      b[i]   = da[47-8*i -: 8];
      b[i+6] = sa[47-8*i -: 8];
    end
    b[12] = 8'($urandom); b[13] = 8'($urandom);
    a = (mode == 2) ? sa : da;
    // R11: strobe in the start cycle carries a junk byte that must not count
    @(negedge clk_i);
    frame_start_i = 1'b1; mode_i = 2'(mode); tx_sa_i = txsa;
    byte_valid_i = 1'b1; byte_i = 8'($urandom);
    for (int i = 0; i < 16; i++) begin act_a[i] = shd_a[i]; act_e[i] = shd_e[i]; end
    sent = 0; since = 99; vcnt = 0; vok = 1;
    while (sent < 14 || since < 4) begin
      @(negedge clk_i);
      host_we_i = 1'b0;
      if (since < 99) since++;
      if (result_valid_o) begin vcnt++; if (since != 2) vok = 0; end
      frame_start_i = 1'b0;
      if (wr && sent == 3) begin
        host_we_i = 1'b1; host_idx_i = 4'(widx); host_addr_i = waddr; host_en_i = wen;
        shd_a[widx] = waddr; shd_e[widx] = wen;
      end
      if (sent < 14 && (!gaps || ($urandom % 3) != 0)) begin
        byte_valid_i = 1'b1; byte_i = b[sent];
        if (sent == ((mode == 2) ? 11 : 5)) since = 0;
        sent++;
      end else byte_valid_i = 1'b0;
    end
    byte_valid_i = 1'b0;
    hit = 0; hidx = 0;
    for (int i = 15; i >= 0; i--) if (act_e[i] && act_a[i] == a) begin hit = 1; hidx = i; end
    ebc  = (a == BC);
    em   = hit || ebc;
    erej = (mode != 2) && !em;
    epmb = (mode == 2) && (a != txsa);
    chk("R4 valid pulse", {63'd0, vok && vcnt == 1}, 64'd1);
    chk("R5 match", {63'd0, match_o}, {63'd0, em});
    chk("R5 idx", {60'd0, match_idx_o}, 64'(hidx));
    chk("R6 bcast", {63'd0, bcast_o}, {63'd0, ebc});
    chk("R8 reject", {63'd0, reject_o}, {63'd0, erej});
    chk("R9 pmb", {63'd0, pmb_o}, {63'd0, epmb});
  endtask

  initial begin
    logic [47:0] x, y, pa, ma;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin shd_a[i] = '0; shd_e[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: reset state of the outputs
    chk("R1 valid", {63'd0, result_valid_o}, 64'd0);
    chk("R1 match", {63'd0, match_o}, 64'd0);
    chk("R1 reject", {63'd0, reject_o}, 64'd0);
    rst_ni = 1'b1;
    // R1: entries come out of reset disabled, all-zero address misses
    run_frame(0, '0, '0, '0, 0, 0, 0, '0, 0);
    // R6: broadcast with empty table
    run_frame(0, BC, 48'h0012_3456_789A, '0, 0, 0, 0, '0, 0);
    // R7: individual and group addresses mixed
    pa = 48'h0200_1122_3344; ma = 48'h0100_5E00_00FB;
    host_write(2, pa, 1);
    host_write(5, ma, 1);
    run_frame(1, pa, '0, '0, 1, 0, 0, '0, 0);
    run_frame(0, ma, '0, '0, 0, 0, 0, '0, 0);
    // R5: duplicate entries, lowest index wins; disabled entry never matches
    x = 48'hA1B2_C3D4_E5F6;
    host_write(9, x, 1);
    host_write(3, x, 1);
    run_frame(0, x, '0, '0, 0, 0, 0, '0, 0);
    host_write(3, x, 0);
    host_write(9, x, 0);
    run_frame(0, x, '0, '0, 0, 0, 0, '0, 0);
    // R2 vs R3: transmit takes SA, not DA
    y = 48'h0A0B_0C0D_0E0F;
    run_frame(2, pa, y, y, 0, 0, 0, '0, 0);
    run_frame(2, y, pa, pa, 1, 0, 0, '0, 0);
    // R9: looped-back SA differs from transmitted one
    run_frame(2, y, pa, pa ^ 48'h1, 0, 0, 0, '0, 0);
    // R10: write during a frame applies only to the next frame
    run_frame(0, y, '0, '0, 0, 1, 7, y, 1);
    run_frame(0, y, '0, '0, 0, 0, 0, '0, 0);
    // R4: a start pulse clears held results
    @(negedge clk_i); frame_start_i = 1'b1; mode_i = 2'd0;
    for (int i = 0; i < 16; i++) begin act_a[i] = shd_a[i]; act_e[i] = shd_e[i]; end
    @(negedge clk_i); frame_start_i = 1'b0;
    chk("R4 clear match", {63'd0, match_o}, 64'd0);
    chk("R4 clear idx", {60'd0, match_idx_o}, 64'd0);
    // random frames
    for (int n = 0; n < 60; n++) begin
      int m, k;
      logic [47:0] d, s, t;
      m = $urandom % 3;
      if ($urandom % 4 == 0) host_write($urandom % 16, 48'($urandom) << 16 | 48'($urandom % 65536), $urandom % 2);
      k = $urandom % 16;
      case ($urandom % 4)
        0: d = shd_a[k];
        1: d = BC;
        default: d = {16'($urandom), 32'($urandom)};
      endcase
      s = ($urandom % 2) ? shd_a[$urandom % 16] : {16'($urandom), 32'($urandom)};
      if (m == 2 && ($urandom % 2)) s = d;
      t = ($urandom % 2) ? s : {16'($urandom), 32'($urandom)};
      run_frame(m, d, s, t, $urandom % 2, $urandom % 4 == 0, $urandom % 16,
                {16'($urandom), 32'($urandom)}, $urandom % 2);
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule